// File: doc/BRIEF.md
# Serial-to-Parallel Output Driver with Level Strobe Latch

This block turns a slow serial command stream into a wide bank of parallel output bits. A host drives a data pin and a shift clock pin. Each rising edge of the shift clock moves one bit into a shift register. A strobe pin controls a level-sensitive holding latch between the shift register and the parallel outputs. While the strobe is high, the outputs are frozen. While the strobe is low, the outputs track the shift register, including every intermediate shift. An active-low clear pin presets the whole latch to ones and leaves the shift register untouched. The last shift stage also drives a serial cascade output, so several drivers can be chained on one data line.

All four pins are treated as asynchronous to the fast system clock. They pass through a two-flop synchronizer, and the rising edge of the shift clock is detected inside the system clock domain. Every output comes straight from a flop.

After power-up, the host must shift in a full frame of WIDTH bits before it opens the strobe for the first time.

Top module: `sipo_strobe_driver`

## Requirements
- R1: Each rising edge of the shift clock pin shifts the data pin into stage 0, and every stage moves up by one. After WIDTH shifts, the bit that was shifted in first is on par_out[WIDTH-1], and the bit shifted in last is on par_out[0].
- R2: While the strobe pin is high and the clear pin is high, par_out keeps its value through any number of shifts.
- R3: While the strobe pin is low and the clear pin is high, par_out follows the shift register and changes after every single shift.
- R4: While the clear pin is low, every par_out bit is 1, whatever the strobe and the shift clock are doing. The shift register keeps its contents and keeps shifting. After clear is released with the strobe low, par_out shows the shift register. After clear is released with the strobe high, par_out stays all ones.
- R5: cascade_out carries the highest shift stage, whether the strobe is high or low.
- R6: While rst is high and just after it, par_out is all ones and the shift register holds zeros. Opening the strobe before any shift therefore gives all zeros, and cascade_out reads 0.
- R7: When HAS_CASCADE is 0, cascade_out stays at 0. The parallel function still works at the configured width, for example 8 bits.
- R8: Holding the shift clock pin high for many system clocks produces exactly one shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst | input | 1 | Synchronous active-high reset |
| ser_din | input | 1 | Serial data pin |
| shift_clk | input | 1 | Shift clock pin; a shift happens on its rising edge |
| strobe | input | 1 | Latch control; low means the latch is transparent, high means it holds |
| clear_n | input | 1 | Active-low latch preset to all ones |
| par_out | output | WIDTH | Parallel outputs from the latch |
| cascade_out | output | 1 | Highest shift stage, used for chaining |

## Verification
The bench builds two copies of the block that share the same pins. One uses the default 24-bit width with the cascade output. The other is an 8-bit build without the cascade output. Because both copies see the same 24-bit frames, the narrow copy must show only the last eight bits shifted in, and its cascade output must stay at 0. This lets one stimulus check how the width and the cascade parameter change the result. The default build also checks the transparent-latch mode, the clear-while-shifting case and a long-held shift clock.

// File: rtl/sipo_drv_pkg.sv
package sipo_drv_pkg;

  // What the holding latch does in a given system clock cycle.
  typedef enum logic [1:0] {
    LAT_HOLD   = 2'd0,
    LAT_LOAD   = 2'd1,
    LAT_PRESET = 2'd2
  } lat_act_e;

  // Bit positions inside the synchronized pin vector.
  localparam int PIN_DIN   = 0;
  localparam int PIN_SCLK  = 1;
  localparam int PIN_STRB  = 2;
  localparam int PIN_CLRN  = 3;
  localparam int PIN_COUNT = 4;

  // Pin levels during reset: clear and strobe are inactive (high).
  localparam logic [PIN_COUNT-1:0] PIN_IDLE = 4'b1100;

endpackage

// File: rtl/sipo_pin_sync.sv
module sipo_pin_sync #(
  parameter int N = 4,
  parameter int DEPTH = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pins_in,
  output logic [N-1:0] pins_sync
);

  logic [DEPTH-1:0][N-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= pins_in;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign pins_sync = stg[DEPTH-1];

endmodule

// File: rtl/sipo_edge_rise.sv
module sipo_edge_rise (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);

  logic lvl_d;

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= 1'b0;
    else     lvl_d <= lvl;
  end

  assign rise = lvl & ~lvl_d;

endmodule

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             din,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (step) q <= {q[WIDTH-2:0], din};
  end

endmodule

// File: rtl/sipo_strobe_latch.sv
module sipo_strobe_latch
  import sipo_drv_pkg::*;
#(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe_s,
  input  logic             clear_n_s,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  lat_act_e act;

  always_comb begin
    if (!clear_n_s)     act = LAT_PRESET;
    else if (!strobe_s) act = LAT_LOAD;
    else                act = LAT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '1;
    end else begin
      case (act)
        LAT_PRESET: q <= '1;
        LAT_LOAD:   q <= d;
        default:    q <= q;
      endcase
    end
  end

endmodule

// File: rtl/sipo_strobe_driver.sv
module sipo_strobe_driver
  import sipo_drv_pkg::*;
#(
  parameter int WIDTH = 24,
  parameter bit HAS_CASCADE = 1'b1,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_din,
  input  logic             shift_clk,
  input  logic             strobe,
  input  logic             clear_n,
  output logic [WIDTH-1:0] par_out,
  output logic             cascade_out
);

  localparam int TOP_BIT = WIDTH - 1;

  logic [PIN_COUNT-1:0] pins_raw;
  logic [PIN_COUNT-1:0] pins_s;
  logic                 din_s;
  logic                 strb_s;
  logic                 clr_n_s;
  logic                 shift_rise;
  logic [WIDTH-1:0]     sr_q;

  assign pins_raw[PIN_DIN]  = ser_din;
  assign pins_raw[PIN_SCLK] = shift_clk;
  assign pins_raw[PIN_STRB] = strobe;
  assign pins_raw[PIN_CLRN] = clear_n;

  sipo_pin_sync #(
    .N(PIN_COUNT), .DEPTH(SYNC_DEPTH), .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk(clk), .rst(rst), .pins_in(pins_raw), .pins_sync(pins_s)
  );

  assign din_s   = pins_s[PIN_DIN];
  assign strb_s  = pins_s[PIN_STRB];
  assign clr_n_s = pins_s[PIN_CLRN];

  sipo_edge_rise u_edge (
    .clk(clk), .rst(rst), .lvl(pins_s[PIN_SCLK]), .rise(shift_rise)
  );

  sipo_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk(clk), .rst(rst), .step(shift_rise), .din(din_s), .q(sr_q)
  );

  sipo_strobe_latch #(.WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst(rst), .strobe_s(strb_s), .clear_n_s(clr_n_s),
    .d(sr_q), .q(par_out)
  );

  generate
    if (HAS_CASCADE) begin : g_casc
      assign cascade_out = sr_q[TOP_BIT];
    end else begin : g_nocasc
      assign cascade_out = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/sipo_strobe_driver_chk.sv
module sipo_strobe_driver_chk #(
  parameter int WIDTH = 24,
  parameter bit HAS_CASCADE = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             din_s,
  input logic             clr_s,
  input logic             strb_s,
  input logic             rise,
  input logic [WIDTH-1:0] sr_q,
  input logic [WIDTH-1:0] par_out,
  input logic             cascade_out
);

  // R1
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> (sr_q[0] == $past(din_s)));

  // R8
  no_spurious_shift_chk: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(sr_q));

  // R2
  strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (strb_s && clr_s) |=> $stable(par_out));

  // R3
  strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!strb_s && clr_s) |=> (par_out == $past(sr_q)));

  // R4
  clear_preset_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_s |=> (par_out == '1));

  generate
    if (HAS_CASCADE && WIDTH > 1) begin : g_casc_chk
      // R5
      cascade_track_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> (cascade_out == $past(sr_q[WIDTH-2])));
    end
  endgenerate

endmodule

bind sipo_strobe_driver sipo_strobe_driver_chk #(
  .WIDTH(WIDTH), .HAS_CASCADE(HAS_CASCADE)
) chk_i (
  .clk(clk), .rst(rst), .din_s(din_s), .clr_s(clr_n_s), .strb_s(strb_s),
  .rise(shift_rise), .sr_q(sr_q), .par_out(par_out), .cascade_out(cascade_out)
);

// File: tb/sipo_strobe_driver_test.sv
module sipo_strobe_driver_test;

  localparam int W = 24;
  localparam int W8 = 8;
  localparam int NFR = 4;
  localparam logic [W-1:0] FRAMES [NFR] = '{24'hA5C30F, 24'h000001, 24'h800000, 24'h5A3CE7};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_din = 1'b0;
  logic shift_clk = 1'b0;
  logic strobe = 1'b1;
  logic clear_n = 1'b1;
  logic [W-1:0]  par_out;
  logic          cascade_out;
  logic [W8-1:0] par8;
  logic          casc8;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [W-1:0] exp_sr = '0;
  logic [W-1:0] held = '1;

  always #5 clk = ~clk;

  sipo_strobe_driver #(.WIDTH(W), .HAS_CASCADE(1'b1)) uut (
    .clk(clk), .rst(rst), .ser_din(ser_din), .shift_clk(shift_clk),
    .strobe(strobe), .clear_n(clear_n), .par_out(par_out), .cascade_out(cascade_out)
  );

  sipo_strobe_driver #(.WIDTH(W8), .HAS_CASCADE(1'b0)) uut8 (
    .clk(clk), .rst(rst), .ser_din(ser_din), .shift_clk(shift_clk),
    .strobe(strobe), .clear_n(clear_n), .par_out(par8), .cascade_out(casc8)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b, input int hold);
    ser_din = b;
    settle();
    shift_clk = 1'b1;
    repeat (hold) @(negedge clk);
    shift_clk = 1'b0;
    settle();
    exp_sr = {exp_sr[W-2:0], b};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle();
    // R6 reset state
    check("R6 par_out at reset", par_out, 32'hFFFFFF);
    check("R6 cascade at reset", cascade_out, 0);
    check("R6 narrow par at reset", par8, 32'hFF);
    strobe = 1'b0;
    settle();
    check("R6 empty shift register", par_out, 0);
    strobe = 1'b1;
    settle();
    held = '0;

    // Table walk: load frame with strobe high, then open strobe.
    for (int f = 0; f < NFR; f++) begin
      for (int i = W - 1; i >= 0; i--) shift_bit(FRAMES[f][i], 6);
      check("R2 frozen during load", par_out, held);
      check("R5 cascade with strobe high", cascade_out, FRAMES[f][W-1]);
      strobe = 1'b0;
      settle();
      check("R1 frame on outputs", par_out, FRAMES[f]);
      check("R7 narrow build keeps last bits", par8, FRAMES[f][W8-1:0]);
      check("R7 cascade tied low", casc8, 0);
      strobe = 1'b1;
      settle();
      held = FRAMES[f];
    end

    // R3 transparent latch follows each shift
    strobe = 1'b0;
    settle();
    shift_bit(1'b1, 6);
    check("R3 follow shift 1", par_out, exp_sr);
    shift_bit(1'b0, 6);
    check("R3 follow shift 2", par_out, exp_sr);
    check("R5 cascade with strobe low", cascade_out, exp_sr[W-1]);
    // R8 long-held shift clock gives one shift
    shift_bit(1'b1, 60);
    check("R8 single shift on long high", par_out, exp_sr);

    // R4 clear with strobe low, shifting continues underneath
    clear_n = 1'b0;
    settle();
    check("R4 clear presets ones", par_out, 32'hFFFFFF);
    shift_bit(1'b0, 6);
    check("R4 ones while shifting", par_out, 32'hFFFFFF);
    check("R5 cascade during clear", cascade_out, exp_sr[W-1]);
    clear_n = 1'b1;
    settle();
    check("R4 shift register intact", par_out, exp_sr);

    // R4 clear with strobe high: latch stays preset after release
    strobe = 1'b1;
    settle();
    clear_n = 1'b0;
    settle();
    check("R4 clear overrides closed strobe", par_out, 32'hFFFFFF);
    clear_n = 1'b1;
    settle();
    check("R4 preset held after release", par_out, 32'hFFFFFF);
    strobe = 1'b0;
    settle();
    check("R4 register still intact", par_out, exp_sr);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule